// File: doc/BRIEF.md
# Banked Level Interrupt Controller

This block gathers level-sensitive interrupt request lines in groups of 32, called banks, and drives a single combined request to a parent interrupt controller. Software reaches each bank through a small window of 32-bit registers on a simple word-addressed register bus. Through the window it can read the raw line state, read the current mask, mask or unmask individual sources with write-one-to-set and write-one-to-clear ports, and read which unmasked sources are active. A helper register returns the number of the highest active unmasked source in the bank, so a handler does not have to scan the bits.

Sources are level triggered. The controller holds no latched request. A source stays active until the device lowers its line. Each line passes through a two-flop synchronizer before it is seen. The bank count is a parameter of 1 or 2. Bank `b` occupies byte addresses `b*0x20` to `b*0x20+0x1F`. On the bus this is word address `b*8 + r`, where `r` selects the register within the bank.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset every mask bit is 1, every status and pending bit is 0, and `irq_out` is low.
- R2: The status register (word `r=0`, byte offset 0x00) returns the line state of the bank's 32 sources, two clock edges after the lines change.
- R3: A write to the set port (word `r=2`, byte offset 0x08) sets the mask bit of every source whose data bit is 1. Bits written as 0 leave their mask bits unchanged.
- R4: A write to the clear port (word `r=3`, byte offset 0x0C) clears the mask bit of every source whose data bit is 1. Bits written as 0 leave their mask bits unchanged. The mask register (word `r=1`, byte offset 0x04) returns the mask in force.
- R5: Writes to words `r=0`, `r=1`, `r=4` and `r=5` change nothing. Reads return zero for words `r=2`, `r=3`, `r=6` and `r=7`, and for any bank number at or beyond the bank count.
- R6: The pending register (word `r=4`, byte offset 0x10) returns status AND NOT mask.
- R7: `irq_out` is high exactly while some bank has a nonzero pending word. It follows a mask write on the edge that performs the write.
- R8: The top-source register (word `r=5`, byte offset 0x14) returns bit 31 = 1 and bits 4:0 = the highest-numbered pending source when the pending word is nonzero, and returns all zeros otherwise.
- R9: Source `n` of bank `b` is line `irq_in[b*32+n]`, and the registers of bank `b` are at word address `b*8 + r`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_BANKS*32 | Level interrupt lines, asynchronous to `clk` |
| addr | input | ADDR_W | Word address |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Combined request to the parent controller |

## Verification
The assertions check on every cycle that:
- status equals the lines from two edges earlier;
- a set or clear write reaches exactly the bits written;
- the mask holds when no mask write happens;
- the top-source index names a pending bit with nothing pending above it;
- `irq_out` agrees with the banks' top-source valid flags.

Only the bench scenarios can show the address decoding across banks and the behaviour of writes to read-only words. They also show that unmapped reads return zero and that the reset values are as stated. The bench compares every visible value against its own model on every cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int SRC_PER_BANK = 32;
    localparam int IDX_W        = $clog2(SRC_PER_BANK);
    localparam int REG_SEL_W    = 3;
    localparam int TOP_VALID_BIT = 31;

    typedef enum logic [REG_SEL_W-1:0] {
        REG_STATUS = 3'd0,
        REG_MASK   = 3'd1,
        REG_SETM   = 3'd2,
        REG_CLRM   = 3'd3,
        REG_PEND   = 3'd4,
        REG_TOP    = 3'd5,
        REG_RSV6   = 3'd6,
        REG_RSV7   = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= din;
            sync_q <= meta_q;
        end
    end

    assign dout = sync_q;

    // Counts edges since reset so the check below never looks before reset.
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    // R2
    sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [SRC_PER_BANK-1:0] status,
    input  logic                    set_we,
    input  logic                    clr_we,
    input  logic [SRC_PER_BANK-1:0] wdata,
    output logic [SRC_PER_BANK-1:0] mask,
    output logic [SRC_PER_BANK-1:0] pending,
    output logic                    top_valid,
    output logic [IDX_W-1:0]        top_idx
);
    logic [SRC_PER_BANK-1:0] mask_q;
    logic [SRC_PER_BANK-1:0] mask_d;

    // A set in the same cycle as a clear wins on any shared bit.
    always_comb begin
        mask_d = mask_q;
        if (clr_we) mask_d = mask_d & ~wdata;
        if (set_we) mask_d = mask_d | wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mask_q <= '1;
        else        mask_q <= mask_d;
    end

    assign mask    = mask_q;
    assign pending = status & ~mask_q;

    // Highest-numbered pending source: the last hit in ascending order wins.
    always_comb begin
        top_valid = 1'b0;
        top_idx   = '0;
        for (int i = 0; i < SRC_PER_BANK; i++) begin
            if (pending[i]) begin
                top_valid = 1'b1;
                top_idx   = IDX_W'(i);
            end
        end
    end

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> ((mask & $past(wdata)) == $past(wdata)));
    // R4
    mask_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !set_we) |=> ((mask & $past(wdata)) == '0));
    // R5
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(mask));
    // R8
    top_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_valid |-> ((pending >> top_idx) == SRC_PER_BANK'(1)));
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ADDR_W    = 6
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_BANKS*SRC_PER_BANK-1:0] irq_in,
    input  logic [ADDR_W-1:0]               addr,
    input  logic                            wr_en,
    input  logic [31:0]                     wdata,
    output logic [31:0]                     rdata,
    output logic                            irq_out
);
    localparam int SRC_W      = NUM_BANKS * SRC_PER_BANK;
    localparam int BANK_FLD_W = ADDR_W - REG_SEL_W;

    logic [SRC_W-1:0]          status_all;
    logic [BANK_FLD_W-1:0]     bank_fld;
    reg_sel_e                  reg_sel;

    logic [SRC_PER_BANK-1:0]   b_mask  [NUM_BANKS];
    logic [SRC_PER_BANK-1:0]   b_pend  [NUM_BANKS];
    logic [IDX_W-1:0]          b_idx   [NUM_BANKS];
    logic [NUM_BANKS-1:0]      b_valid;
    logic [NUM_BANKS-1:0]      b_hit;

    assign bank_fld = addr[ADDR_W-1:REG_SEL_W];
    assign reg_sel  = reg_sel_e'(addr[REG_SEL_W-1:0]);

    irqc_sync #(.W(SRC_W)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (irq_in),
        .dout (status_all)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic sel;
        assign sel = (bank_fld == BANK_FLD_W'(b));

        irqc_bank u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .status   (status_all[b*SRC_PER_BANK +: SRC_PER_BANK]),
            .set_we   (wr_en && sel && (reg_sel == REG_SETM)),
            .clr_we   (wr_en && sel && (reg_sel == REG_CLRM)),
            .wdata    (wdata),
            .mask     (b_mask[b]),
            .pending  (b_pend[b]),
            .top_valid(b_valid[b]),
            .top_idx  (b_idx[b])
        );

        assign b_hit[b] = |b_pend[b];
    end

    assign irq_out = |b_hit;

    always_comb begin
        rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_fld == BANK_FLD_W'(b)) begin
                unique case (reg_sel)
                    REG_STATUS: rdata = status_all[b*SRC_PER_BANK +: SRC_PER_BANK];
                    REG_MASK:   rdata = b_mask[b];
                    REG_PEND:   rdata = b_pend[b];
                    REG_TOP: begin
                        rdata[TOP_VALID_BIT] = b_valid[b];
                        rdata[IDX_W-1:0]     = b_idx[b];
                    end
                    REG_SETM, REG_CLRM, REG_RSV6, REG_RSV7: rdata = '0;
                    default:    rdata = '0;
                endcase
            end
        end
    end

    // R7
    cascade_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out == (|b_valid));
    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq_out);
endmodule

// File: tb/banked_irq_ctrl_test.sv
module banked_irq_ctrl_test;
    localparam int NB = 2;
    localparam int AW = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NB*32-1:0] irq_in = '0;
    logic [AW-1:0]   addr = '0;
    logic            wr_en = 1'b0;
    logic [31:0]     wdata = '0;
    logic [31:0]     rdata;
    logic            irq_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    banked_irq_ctrl #(.NUM_BANKS(NB), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq_out(irq_out)
    );

    // Behavioural reference: two-stage line delay and a mask word per bank.
    logic [NB*32-1:0] m_d1, m_d2, m_mask;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_d1 = '0; m_d2 = '0; m_mask = '1;
        end else begin
            int bank, off;
            bank = int'(addr) / 8;
            off  = (int'(addr) % 8) * 4;
            if (wr_en && bank < NB) begin
                if (off == 'h08) m_mask[bank*32 +: 32] = m_mask[bank*32 +: 32] | wdata;
                if (off == 'h0C) m_mask[bank*32 +: 32] = m_mask[bank*32 +: 32] & ~wdata;
            end
            m_d2 = m_d1;
            m_d1 = irq_in;
        end
    end

    function automatic logic [31:0] exp_read(int a);
        int bank, off;
        logic [31:0] st, mk, pd, top;
        bank = a / 8;
        off  = (a % 8) * 4;
        if (bank >= NB) return 32'h0;
        st = m_d2[bank*32 +: 32];
        mk = m_mask[bank*32 +: 32];
        pd = st & ~mk;
        top = 32'h0;
        for (int i = 0; i < 32; i++) if (pd[i]) top = 32'h8000_0000 | i;
        case (off)
            'h00: return st;
            'h04: return mk;
            'h10: return pd;
            'h14: return top;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case ((a % 8) * 4)
            'h00: return "R2";
            'h04: return "R3/R4";
            'h10: return "R6";
            'h14: return "R8";
            default: return "R5";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Per-cycle comparison, 1 ns after each falling edge.
    always @(negedge clk) begin
        #1;
        if (!done) begin
            logic any;
            any = |(m_d2 & ~m_mask);
            check("R7 irq_out", {31'b0, irq_out}, {31'b0, any});
            check(tag_of(int'(addr)), rdata, exp_read(int'(addr)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic wr(int a, logic [31:0] d);
        @(negedge clk);
        addr = AW'(a); wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(int a, logic [31:0] exp, string req);
        @(negedge clk);
        addr = AW'(a);
        #2;
        check(req, rdata, exp);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values, read while reset is held
        check("R1 irq_out in reset", {31'b0, irq_out}, 32'h0);
        rst_n = 1'b1;
        rd(1, 32'hFFFF_FFFF, "R1 mask bank0");
        rd(9, 32'hFFFF_FFFF, "R1 mask bank1");
        rd(4, 32'h0, "R1 pending bank0");

        // R2: lines visible in status two edges later, masked so no pending
        irq_in = 64'h8000_0000_0000_0005;
        idle(3);
        rd(0, 32'h0000_0005, "R2 status bank0");
        rd(8, 32'h8000_0000, "R2 R9 status bank1");
        rd(4, 32'h0, "R6 pending all masked");

        // R4: unmask source 2 of bank 0
        wr(3, 32'h0000_0004);
        rd(1, 32'hFFFF_FFFB, "R4 mask after clear");
        rd(4, 32'h0000_0004, "R6 pending after clear");
        rd(5, 32'h8000_0002, "R8 top bank0");
        check("R7 irq_out high", {31'b0, irq_out}, 32'h1);

        // R3: zero bits do nothing, one bits mask
        wr(2, 32'h0);
        rd(1, 32'hFFFF_FFFB, "R3 zero write no effect");
        wr(2, 32'h0000_0004);
        rd(1, 32'hFFFF_FFFF, "R3 mask after set");
        check("R7 irq_out low", {31'b0, irq_out}, 32'h0);

        // R5: read-only words ignore writes; unmapped reads are zero
        wr(1, 32'h0);
        wr(4, 32'hFFFF_FFFF);
        wr(5, 32'hFFFF_FFFF);
        wr(0, 32'h0);
        rd(1, 32'hFFFF_FFFF, "R5 mask unchanged");
        rd(0, 32'h0000_0005, "R5 status unchanged");
        rd(2, 32'h0, "R5 set port reads zero");
        rd(3, 32'h0, "R5 clear port reads zero");
        rd(6, 32'h0, "R5 word 6 zero");
        rd(16, 32'h0, "R5 bank beyond count zero");
        wr(19, 32'hFFFF_FFFF);
        rd(1, 32'hFFFF_FFFF, "R5 bank2 write ignored");

        // R9 / R8: bank 1 top source 31
        wr(11, 32'h8000_0000);
        rd(12, 32'h8000_0000, "R9 pending bank1");
        rd(13, 32'h8000_001F, "R8 top bank1 index 31");
        rd(5, 32'h0, "R8 top bank0 empty");

        // Line drop clears pending with no software action (R2, R7)
        irq_in = '0;
        idle(3);
        check("R7 irq_out after line drop", {31'b0, irq_out}, 32'h0);

        // Mixed traffic compared against the model every cycle
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (i % 7 == 0) irq_in = {$urandom, $urandom};
            addr  = AW'($urandom_range(0, 17));
            wdata = $urandom;
            wr_en = ($urandom_range(0, 2) == 0);
        end
        @(negedge clk);
        wr_en = 1'b0;
        idle(4);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule